// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps a small direct-mapped cache coherent with its peers on a shared broadcast bus, using a three-state write-invalidate scheme. Each line is Invalid (no data), Shared (clean, read-only) or Exclusive (the only copy, writable, dirty). CPU reads and writes are looked up against the stored tag and state. A hit finishes in the same cycle. A miss raises a bus request. Once the external arbiter grants the bus, the controller places the transaction on it, spending one grant on each transaction.

The controller also watches the read misses and write misses that other masters place on the bus. A snooped miss that finds the line Exclusive makes the controller supply the dirty block and tell memory to abandon its own response. The line then drops to Shared or Invalid, depending on the kind of miss. While a CPU miss waits for the bus, the transaction it will place is worked out again every cycle from the line's current state. A snoop that changes the line before the grant therefore changes what is issued.

The address is split as `addr = {tag, index}`, with the index in the low `log2(N_LINES)` bits. Bus commands are encoded 0 none, 1 read miss, 2 write miss, 3 write-back.

Top module: `snoop_msi_ctrl`

## Requirements
- R1: After reset, every line is Invalid. `bus_req`, `cpu_ready` and `snp_abort` are low, so the first access to any address misses.
- R2: A CPU read to a Shared or Exclusive line with a matching tag, or a CPU write to an Exclusive line with a matching tag, raises `cpu_ready` in the same cycle. It raises no bus request and places no command.
- R3: A CPU read to an Invalid line raises `bus_req` from the next cycle. On the first grant it places command 1 with the request address, raises `cpu_ready` in that cycle, and leaves the line Shared.
- R4: A CPU write to an Invalid line, or to a Shared line of any tag, is a miss. On grant it places command 2 with the request address, completes, and leaves the line Exclusive, so a following write to that address hits.
- R5: A miss whose line is Exclusive with a different tag first uses one grant for command 3. That command carries the victim address `{old tag, index}`, leaves `cpu_ready` low and invalidates the line. The next grant places the miss itself. A read ends Shared and a write ends Exclusive. A Shared victim is replaced with no write-back.
- R6: `bus_cmd` is 0 and the line is left unchanged in every cycle without a grant. `bus_req` stays high until the miss completes.
- R7: A snooped read miss (command 1) that matches an Exclusive line raises `snp_abort` in the same cycle and leaves the line Shared. A snooped read miss that matches a Shared line raises no abort and leaves the line Shared.
- R8: A snooped write miss (command 2) that matches a line invalidates it. It raises `snp_abort` in the same cycle only if the line was Exclusive.
- R9: A snoop whose tag differs from the stored tag, or whose command is 0 or 3, raises no abort and changes no line.
- R10: A snoop that changes the target line while a miss waits for its grant changes the transaction placed on grant. An invalidated Exclusive victim is not written back. The miss then goes out directly.
- R11: If a CPU request and a snooped read or write miss address the same index in the same cycle, the CPU request does not complete in that cycle and the snoop takes effect. The request is looked up again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU block address `{tag, index}` |
| cpu_ready | output | 1 | Request completes in this cycle |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Bus granted for this cycle |
| bus_cmd | output | 2 | Command placed on the bus (0 none, 1 read miss, 2 write miss, 3 write-back) |
| bus_addr | output | ADDR_W | Address of the placed command |
| snoop_valid | input | 1 | A transaction from another master is on the bus |
| snoop_cmd | input | 2 | Command of the snooped transaction, same encoding |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |
| snp_abort | output | 1 | This cache supplies the dirty block; memory must abandon its response |

## Verification
A line left in the wrong state shows up at the ports on the next access to that line. A hit that should have missed raises `cpu_ready` with no bus request. A miss that should have hit raises `bus_req`. A lost Exclusive state shows up as a missing `snp_abort` on the next snoop, or as a missing command 3 on replacement. A mistake in the wait-for-grant path shows up on the first granted cycle, where the command and address tell whether the transaction was worked out from the line's updated state. The vectors therefore always follow a state-changing event with an access or snoop that tells the possible states apart, within one or two cycles.

// File: rtl/msi_pkg.sv
package msi_pkg;
    typedef enum logic [1:0] {
        L_INV = 2'd0,
        L_SHR = 2'd1,
        L_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_WR   = 2'd2,
        BC_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        C_IDLE = 1'b0,
        C_ARB  = 1'b1
    } ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_pkg::*;
#(
    parameter int N_LINES = 4,
    parameter int TAG_W   = 4,
    localparam int IDX_W  = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_a,
    output line_st_e         rd_st_a,
    output logic [TAG_W-1:0] rd_tag_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output line_st_e         rd_st_b,
    output logic [TAG_W-1:0] rd_tag_b,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st,
    input  logic             cpu_we,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [TAG_W-1:0] cpu_tag,
    input  line_st_e         cpu_st
);
    typedef struct packed {
        line_st_e [N_LINES-1:0]            st;
        logic     [N_LINES-1:0][TAG_W-1:0] tag;
    } store_t;

    store_t store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (snp_we) begin
            store_d.st[snp_idx] = snp_st;
        end
        // A granted CPU transaction owns the bus, so it wins any overlap.
        if (cpu_we) begin
            store_d.st[cpu_idx]  = cpu_st;
            store_d.tag[cpu_idx] = cpu_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign rd_st_a  = store_q.st[rd_idx_a];
    assign rd_tag_a = store_q.tag[rd_idx_a];
    assign rd_st_b  = store_q.st[rd_idx_b];
    assign rd_tag_b = store_q.tag[rd_idx_b];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_cmd,
    input  logic [TAG_W-1:0] snoop_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             touch,
    output logic             upd_we,
    output line_st_e         upd_st,
    output logic             abort
);
    logic match;

    always_comb begin
        touch  = snoop_valid && (snoop_cmd == BC_RD || snoop_cmd == BC_WR);
        match  = touch && (line_st != L_INV) && (line_tag == snoop_tag);
        upd_we = 1'b0;
        upd_st = line_st;
        abort  = 1'b0;
        if (match) begin
            if (snoop_cmd == BC_RD) begin
                if (line_st == L_EXC) begin
                    upd_we = 1'b1;
                    upd_st = L_SHR;
                    abort  = 1'b1;
                end
            end else begin
                upd_we = 1'b1;
                upd_st = L_INV;
                abort  = (line_st == L_EXC);
            end
        end
    end
endmodule

// File: rtl/snoop_msi_ctrl.sv
module snoop_msi_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int N_LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snp_abort
);
    localparam int IDX_W = $clog2(N_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           fsm;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] lk_idx, snp_idx;
    logic [TAG_W-1:0] lk_tag, tag_a, tag_b;
    line_st_e         st_a, st_b, snp_st, wr_st;
    logic             snp_touch, snp_we, wr_en, lk_we, collide, hit_ok, need_wb;
    logic [TAG_W-1:0] wr_tag;
    bus_cmd_e         cmd_e;

    assign snp_idx = snoop_addr[IDX_W-1:0];

    msi_line_store #(.N_LINES(N_LINES), .TAG_W(TAG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (lk_idx),
        .rd_st_a  (st_a),
        .rd_tag_a (tag_a),
        .rd_idx_b (snp_idx),
        .rd_st_b  (st_b),
        .rd_tag_b (tag_b),
        .snp_we   (snp_we),
        .snp_idx  (snp_idx),
        .snp_st   (snp_st),
        .cpu_we   (wr_en),
        .cpu_idx  (lk_idx),
        .cpu_tag  (wr_tag),
        .cpu_st   (wr_st)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snoop_valid (snoop_valid),
        .snoop_cmd   (snoop_cmd),
        .snoop_tag   (snoop_addr[ADDR_W-1:IDX_W]),
        .line_st     (st_b),
        .line_tag    (tag_b),
        .touch       (snp_touch),
        .upd_we      (snp_we),
        .upd_st      (snp_st),
        .abort       (snp_abort)
    );

    always_comb begin
        ctl_d     = ctl_q;
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        cmd_e     = BC_NONE;
        bus_addr  = '0;
        wr_en     = 1'b0;
        wr_tag    = '0;
        wr_st     = L_INV;

        // While waiting, the latched request is looked up; otherwise the live one.
        if (ctl_q.fsm == C_ARB) begin
            lk_idx = ctl_q.addr[IDX_W-1:0];
            lk_tag = ctl_q.addr[ADDR_W-1:IDX_W];
            lk_we  = ctl_q.we;
        end else begin
            lk_idx = cpu_addr[IDX_W-1:0];
            lk_tag = cpu_addr[ADDR_W-1:IDX_W];
            lk_we  = cpu_we;
        end

        collide = snp_touch && (snp_idx == lk_idx);
        hit_ok  = (st_a != L_INV) && (tag_a == lk_tag) && (!lk_we || st_a == L_EXC);
        need_wb = (st_a == L_EXC) && (tag_a != lk_tag);

        unique case (ctl_q.fsm)
            C_IDLE: begin
                if (cpu_req && !collide) begin
                    if (hit_ok) begin
                        cpu_ready = 1'b1;
                    end else begin
                        ctl_d.fsm  = C_ARB;
                        ctl_d.we   = cpu_we;
                        ctl_d.addr = cpu_addr;
                    end
                end
            end
            C_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    wr_en = 1'b1;
                    if (need_wb) begin
                        cmd_e    = BC_WB;
                        bus_addr = {tag_a, lk_idx};
                        wr_tag   = tag_a;
                        wr_st    = L_INV;
                    end else begin
                        cmd_e     = lk_we ? BC_WR : BC_RD;
                        bus_addr  = ctl_q.addr;
                        wr_tag    = lk_tag;
                        wr_st     = lk_we ? L_EXC : L_SHR;
                        cpu_ready = 1'b1;
                        ctl_d.fsm = C_IDLE;
                    end
                end
            end
            default: ctl_d.fsm = C_IDLE;
        endcase
    end

    assign bus_cmd = cmd_e;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/msi_ctrl_chk.sv
module msi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic       snoop_valid,
    input logic [1:0] snoop_cmd,
    input logic       snp_abort
);
    a_r6_cmd_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);

    a_r3_miss_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd1 || bus_cmd == 2'd2) |-> cpu_ready);

    a_r5_wb_no_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |-> !cpu_ready);

    a_r5_wb_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == 2'd3) |=> bus_req);

    a_r7_abort_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snoop_valid && (snoop_cmd == 2'd1 || snoop_cmd == 2'd2)));
endmodule

bind snoop_msi_ctrl msi_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ready   (cpu_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .snoop_valid (snoop_valid),
    .snoop_cmd   (snoop_cmd),
    .snp_abort   (snp_abort)
);

// File: tb/snoop_msi_ctrl_tb.sv
module snoop_msi_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic       cpu_ready, bus_req, snp_abort;
    logic       bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic       snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = '0;
    logic [5:0] snoop_addr = '0;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    snoop_msi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .snp_abort(snp_abort)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic       req;
        logic       we;
        logic [5:0] a;
        logic       sv;
        logic [1:0] sc;
        logic [5:0] sa;
        logic       g;
        logic       rdy;
        logic       breq;
        logic [1:0] cmd;
        logic [5:0] ba;
        logic       ab;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R1 quiet after reset
        '{4'd3,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R3 read miss seen
        '{4'd6,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b1,2'd0,6'h00,1'b0}, // R6 waiting, no command
        '{4'd3,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd1,6'h00,1'b0}, // R3 read miss placed
        '{4'd2,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R2 read hit Shared
        '{4'd4,  1'b1,1'b1,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R4 write to Shared misses
        '{4'd4,  1'b1,1'b1,6'h00, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h00,1'b0}, // R4 write miss placed
        '{4'd2,  1'b1,1'b1,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R2 write hit Exclusive
        '{4'd7,  1'b0,1'b0,6'h00, 1'b1,2'd1,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b1}, // R7 snoop read on Exclusive
        '{4'd7,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R7 line still readable
        '{4'd4,  1'b1,1'b1,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R4 now Shared, write misses
        '{4'd8,  1'b1,1'b1,6'h00, 1'b1,2'd2,6'h00, 1'b0, 1'b0,1'b1,2'd0,6'h00,1'b0}, // R8 snoop write on Shared
        '{4'd10, 1'b1,1'b1,6'h00, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h00,1'b0}, // R10 reissued write miss
        '{4'd5,  1'b1,1'b0,6'h04, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R5 read replaces Exclusive
        '{4'd5,  1'b1,1'b0,6'h04, 1'b0,2'd0,6'h00, 1'b1, 1'b0,1'b1,2'd3,6'h00,1'b0}, // R5 write-back victim
        '{4'd5,  1'b1,1'b0,6'h04, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd1,6'h04,1'b0}, // R5 then read miss
        '{4'd9,  1'b0,1'b0,6'h00, 1'b1,2'd2,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R9 snoop other tag
        '{4'd9,  1'b1,1'b0,6'h04, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R9 line kept
        '{4'd4,  1'b1,1'b1,6'h05, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R4 write to Invalid
        '{4'd4,  1'b1,1'b1,6'h05, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h05,1'b0}, // R4 write miss placed
        '{4'd5,  1'b1,1'b1,6'h09, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R5 write replaces Exclusive
        '{4'd8,  1'b1,1'b1,6'h09, 1'b1,2'd2,6'h05, 1'b0, 1'b0,1'b1,2'd0,6'h00,1'b1}, // R8 victim stolen while waiting
        '{4'd10, 1'b1,1'b1,6'h09, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h09,1'b0}, // R10 no write-back now
        '{4'd7,  1'b0,1'b0,6'h00, 1'b1,2'd1,6'h09, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b1}, // R7 downgrade
        '{4'd4,  1'b1,1'b1,6'h09, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R4 Shared write misses
        '{4'd4,  1'b1,1'b1,6'h09, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h09,1'b0}, // R4 placed, no write-back
        '{4'd11, 1'b1,1'b0,6'h09, 1'b1,2'd2,6'h09, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b1}, // R11 same-index collision
        '{4'd11, 1'b1,1'b0,6'h09, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R11 retried, now a miss
        '{4'd3,  1'b1,1'b0,6'h09, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd1,6'h09,1'b0}, // R3 read miss placed
        '{4'd9,  1'b0,1'b0,6'h00, 1'b1,2'd3,6'h09, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R9 snooped write-back ignored
        '{4'd9,  1'b1,1'b0,6'h09, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R9 still Shared
        '{4'd4,  1'b1,1'b1,6'h0A, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R4 write miss
        '{4'd4,  1'b1,1'b1,6'h0A, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h0A,1'b0}, // R4 placed
        '{4'd5,  1'b1,1'b1,6'h0E, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R5 write replaces dirty
        '{4'd5,  1'b1,1'b1,6'h0E, 1'b0,2'd0,6'h00, 1'b1, 1'b0,1'b1,2'd3,6'h0A,1'b0}, // R5 write-back first
        '{4'd5,  1'b1,1'b1,6'h0E, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd2,6'h0E,1'b0}, // R5 then write miss
        '{4'd2,  1'b1,1'b1,6'h0E, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}, // R2 stays Exclusive
        '{4'd5,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R5 replace Shared line
        '{4'd5,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b1, 1'b1,1'b1,2'd1,6'h00,1'b0}, // R5 no write-back for clean
        '{4'd7,  1'b0,1'b0,6'h00, 1'b1,2'd1,6'h00, 1'b0, 1'b0,1'b0,2'd0,6'h00,1'b0}, // R7 snoop read on Shared
        '{4'd7,  1'b1,1'b0,6'h00, 1'b0,2'd0,6'h00, 1'b0, 1'b1,1'b0,2'd0,6'h00,1'b0}  // R7 still Shared
    };

    task automatic check(input int vi, input int rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL step %0d R%0d %s act=%0h exp=%0h", vi, rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic req, input logic we, input logic [5:0] a,
                         input logic sv, input logic [1:0] sc, input logic [5:0] sa, input logic g);
        cpu_req = req; cpu_we = we; cpu_addr = a;
        snoop_valid = sv; snoop_cmd = sc; snoop_addr = sa; bus_gnt = g;
    endtask

    task automatic expect_out(input int vi, input int rq, input logic rdy, input logic breq,
                              input logic [1:0] cmd, input logic [5:0] ba, input logic ab);
        check(vi, rq, "cpu_ready", int'(cpu_ready), int'(rdy));
        check(vi, rq, "bus_req", int'(bus_req), int'(breq));
        check(vi, rq, "bus_cmd", int'(bus_cmd), int'(cmd));
        if (cmd != 2'd0) check(vi, rq, "bus_addr", int'(bus_addr), int'(ba));
        check(vi, rq, "snp_abort", int'(snp_abort), int'(ab));
    endtask

    initial begin
        #100000;
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired R1 act=0 exp=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].req, VECS[i].we, VECS[i].a, VECS[i].sv, VECS[i].sc, VECS[i].sa, VECS[i].g);
            #1;
            expect_out(i, int'(VECS[i].rq), VECS[i].rdy, VECS[i].breq, VECS[i].cmd, VECS[i].ba, VECS[i].ab);
        end

        // R1: reset while a miss waits for the bus clears the request and all lines.
        @(negedge clk);
        drive(1'b1, 1'b0, 6'h02, 1'b0, 2'd0, 6'h00, 1'b0);
        @(negedge clk);
        #1;
        expect_out(100, 6, 1'b0, 1'b1, 2'd0, 6'h00, 1'b0);   // R6 waiting
        @(negedge clk);
        drive(1'b0, 1'b0, 6'h00, 1'b0, 2'd0, 6'h00, 1'b0);
        rst_n = 1'b0;
        #1;
        expect_out(101, 1, 1'b0, 1'b0, 2'd0, 6'h00, 1'b0);   // R1 request dropped
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b1, 1'b1, 6'h0E, 1'b0, 2'd0, 6'h00, 1'b0);
        #1;
        expect_out(102, 1, 1'b0, 1'b0, 2'd0, 6'h00, 1'b0);   // R1 former Exclusive now misses
        @(negedge clk);
        drive(1'b1, 1'b1, 6'h0E, 1'b0, 2'd0, 6'h00, 1'b1);
        #1;
        expect_out(103, 1, 1'b1, 1'b1, 2'd2, 6'h0E, 1'b0);   // R1 no write-back after reset
        @(negedge clk);
        drive(1'b0, 1'b0, 6'h00, 1'b1, 2'd1, 6'h06, 1'b0);
        #1;
        expect_out(104, 9, 1'b0, 1'b0, 2'd0, 6'h00, 1'b0);   // R9 other tag on Exclusive line
        @(negedge clk);
        drive(1'b0, 1'b0, 6'h00, 1'b0, 2'd0, 6'h00, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule